// File: doc/BRIEF.md
# RTC Event Flag and Interrupt Register

This block collects the event notifications of a real-time clock and turns them into an interrupt request. Three single-cycle pulses arrive from elsewhere in the clock: a periodic tick, an alarm match, and the end of a time update. Each pulse sets its own sticky flag. Each flag stays set until software reads the status byte, and that one read clears all of them together. A pulse that lands in the same cycle as the clearing read is kept, so no event is lost.

A small control byte holds one enable per event and a transfer-hold bit. The hold bit tells the time-keeping logic to stop copying time bytes into the user-visible buffer. Setting it also turns off the update-ended enable. The summary interrupt bit is the OR of each enable ANDed with its flag. It is formed combinationally, and the active-low interrupt pin follows it. A separate read-only integrity byte reports whether the backup supply is still good.

Top module: `rtc_evt_irq`

## Requirements
- R1: After reset, all three flags, all three enables and the hold bit are 0, `irq_n` is 1, and the status byte reads 0x00.
- R2: A pulse on `tick_i`, `alarm_i` or `upd_end_i` sets the status bit 6, 5 or 4 respectively from the next cycle on, and that bit stays set until a clearing read.
- R3: Status bit 7 is 1 exactly when (bit 6 of control and the periodic flag), (bit 5 of control and the alarm flag) or (bit 4 of control and the update flag) holds. `irq_n` is the inverse of status bit 7 and follows an enable change in the cycle after the write.
- R4: A cycle with `reg_rd` = 1 and `reg_addr` = 1 (the status byte) clears all three flags at that clock edge. The status byte is read combinationally in that same cycle, before the clear.
- R5: A flag whose event pulse coincides with a clearing status read is 1 after the read.
- R6: Address 2 reads `{bkup_ok_i, 7'b0}`. Bit 7 follows the input with no delay.
- R7: A write to address 0 loads the periodic, alarm and update enables from data bits 6, 5 and 4, and the hold bit from data bit 7. Address 0 reads back `{hold, enables, 4'b0}`.
- R8: Writing bit 7 = 1 to address 0 forces the update enable to 0, whatever data bit 4 holds, and drives `xfer_hold` to 1. Writing bit 7 = 0 drives `xfer_hold` to 0.
- R9: Writes to address 1 or 2 change no flag, no enable and no hold state.
- R10: Status bits 3 to 0 always read 0, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Periodic tick pulse |
| alarm_i | input | 1 | Alarm match pulse |
| upd_end_i | input | 1 | End-of-update pulse |
| bkup_ok_i | input | 1 | Backup supply good |
| reg_addr | input | ADDR_W | Register select: 0 control, 1 status, 2 integrity |
| reg_rd | input | 1 | Read strobe (side effect on status only) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| irq_n | output | 1 | Active-low interrupt request |
| xfer_hold | output | 1 | Blocks the copy of time bytes to the user buffer |

## Verification
The bench goes after the cycle in which an event and a clearing read coincide. A design that lets the clear win would read that flag back as 0 and lose the event. It writes the hold bit together with data bit 4 set; a design that stored bit 4 literally would leave update interrupts enabled while transfers are held. It writes 0xFF to the status and integrity addresses; a decoder that ignored the address would load the control byte or disturb the flags. Random traffic mixes all three pulses with reads, writes and enable changes. This checks that the summary bit, and with it `irq_n`, track the AND-OR of enables and flags in every cycle rather than only when a flag is first set.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
   // event order inside flag and enable vectors (MSB first in the byte)
   localparam int EV_UPD = 0;
   localparam int EV_ALM = 1;
   localparam int EV_PER = 2;
   localparam int EVT_N  = 3;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_STAT  = 2'd1,
      SEL_INTEG = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] evt_i,
   input  logic         clr_i,
   output logic [N-1:0] flag_o
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_flag
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= 1'b0;
            else
               q <= evt_i[g] | (q & ~clr_i);  // set beats clear
         end
         assign flag_o[g] = q;
      end
   endgenerate
endmodule

// File: rtl/rtc_evt_ctrl.sv
module rtc_evt_ctrl #(
   parameter int N       = 3,
   parameter int UPD_IDX = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic         hold_d,
   input  logic [N-1:0] en_d,
   output logic [N-1:0] en_o,
   output logic         hold_o
);
   logic [N-1:0] en_next;

   always_comb begin
      en_next = en_d;
      if (hold_d) en_next[UPD_IDX] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o   <= '0;
         hold_o <= 1'b0;
      end else if (we_i) begin
         en_o   <= en_next;
         hold_o <= hold_d;
      end
   end
endmodule

// File: rtl/rtc_evt_rdmux.sv
module rtc_evt_rdmux #(
   parameter int N      = 3,
   parameter int DATA_W = 8
) (
   input  logic              sel_ctrl,
   input  logic              sel_stat,
   input  logic              sel_integ,
   input  logic              hold_i,
   input  logic [N-1:0]      en_i,
   input  logic              summ_i,
   input  logic [N-1:0]      flag_i,
   input  logic              bkup_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] ctrl_b, stat_b, integ_b;

   always_comb begin
      ctrl_b  = '0;
      stat_b  = '0;
      integ_b = '0;
      ctrl_b[DATA_W-1]       = hold_i;
      ctrl_b[DATA_W-2 -: N]  = en_i;
      stat_b[DATA_W-1]       = summ_i;
      stat_b[DATA_W-2 -: N]  = flag_i;
      integ_b[DATA_W-1]      = bkup_i;
      unique case (1'b1)
         sel_ctrl:  rdata_o = ctrl_b;
         sel_stat:  rdata_o = stat_b;
         sel_integ: rdata_o = integ_b;
         default:   rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
   import rtc_evt_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              alarm_i,
   input  logic              upd_end_i,
   input  logic              bkup_ok_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_n,
   output logic              xfer_hold
);
   localparam int N     = EVT_N;
   localparam int RSV_W = DATA_W - 1 - N;

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (RSV_W < 0) begin : g_bad_data
         $error("DATA_W too small for summary plus event bits");
      end
   endgenerate

   logic           sel_ctrl, sel_stat, sel_integ;
   logic [N-1:0]   evt_vec, flag_q, en_q;
   logic           summ;
   logic           unused_wbits;

   assign sel_ctrl  = (reg_addr == ADDR_W'(SEL_CTRL));
   assign sel_stat  = (reg_addr == ADDR_W'(SEL_STAT));
   assign sel_integ = (reg_addr == ADDR_W'(SEL_INTEG));

   always_comb begin
      evt_vec         = '0;
      evt_vec[EV_PER] = tick_i;
      evt_vec[EV_ALM] = alarm_i;
      evt_vec[EV_UPD] = upd_end_i;
   end

   rtc_evt_flags #(.N(N)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_i  (evt_vec),
      .clr_i  (reg_rd & sel_stat),
      .flag_o (flag_q)
   );

   rtc_evt_ctrl #(.N(N), .UPD_IDX(EV_UPD)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (reg_wr & sel_ctrl),
      .hold_d (reg_wdata[DATA_W-1]),
      .en_d   (reg_wdata[DATA_W-2 -: N]),
      .en_o   (en_q),
      .hold_o (xfer_hold)
   );

   assign summ  = |(en_q & flag_q);
   assign irq_n = ~summ;

   rtc_evt_rdmux #(.N(N), .DATA_W(DATA_W)) u_rd (
      .sel_ctrl  (sel_ctrl),
      .sel_stat  (sel_stat),
      .sel_integ (sel_integ),
      .hold_i    (xfer_hold),
      .en_i      (en_q),
      .summ_i    (summ),
      .flag_i    (flag_q),
      .bkup_i    (bkup_ok_i),
      .rdata_o   (reg_rdata)
   );

   generate
      if (RSV_W > 0) begin : g_rsv
         assign unused_wbits = ^reg_wdata[RSV_W-1:0];
      end else begin : g_norsv
         assign unused_wbits = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rtc_evt_irq_chk.sv
module rtc_evt_irq_chk #(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8,
   parameter int N      = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              alarm_i,
   input logic              upd_end_i,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_rd,
   input logic              reg_wr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [N-1:0]      flag_q,
   input logic [N-1:0]      en_q,
   input logic              irq_n,
   input logic              xfer_hold
);
   logic [N-1:0] ev;
   logic         rd_stat, wr_ctrl, wr_ro;
   assign ev      = {tick_i, alarm_i, upd_end_i};
   assign rd_stat = reg_rd && (reg_addr == ADDR_W'(1));
   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(0));
   assign wr_ro   = reg_wr && (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2));

   a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev) |=> ((flag_q & $past(ev)) == $past(ev)));

   a_r3_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_n == !(|(en_q & flag_q)));

   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && ev == '0) |=> (flag_q == '0));

   a_r5_coincident_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && (|ev)) |=> (flag_q == $past(ev)));

   a_r8_hold_clears_uie: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && reg_wdata[DATA_W-1]) |=> (xfer_hold && !en_q[0]));

   a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ro && !reg_rd && ev == '0) |=> ($stable(flag_q) && $stable(en_q) && $stable(xfer_hold)));
endmodule

bind rtc_evt_irq rtc_evt_irq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N(N)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_i    (tick_i),
   .alarm_i   (alarm_i),
   .upd_end_i (upd_end_i),
   .reg_addr  (reg_addr),
   .reg_rd    (reg_rd),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .flag_q    (flag_q),
   .en_q      (en_q),
   .irq_n     (irq_n),
   .xfer_hold (xfer_hold)
);

// File: tb/rtc_evt_irq_test.sv
`timescale 1ns/100ps
module rtc_evt_irq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 0, alarm_i = 0, upd_end_i = 0, bkup_ok_i = 0;
   logic [1:0] reg_addr = 0;
   logic       reg_rd = 0, reg_wr = 0;
   logic [7:0] reg_wdata = 0;
   logic [7:0] reg_rdata;
   logic       irq_n, xfer_hold;

   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // model state: {periodic, alarm, update}
   logic [2:0] m_flag = 0, m_en = 0;
   logic       m_hold = 0;

   always #2.5 clk = ~clk;

   rtc_evt_irq uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .alarm_i(alarm_i),
      .upd_end_i(upd_end_i), .bkup_ok_i(bkup_ok_i), .reg_addr(reg_addr),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_n(irq_n), .xfer_hold(xfer_hold)
   );

   function automatic logic m_summ();
      return |(m_en & m_flag);
   endfunction

   function automatic logic [7:0] m_read(input logic [1:0] a, input logic bk);
      case (a)
         2'd0:    return {m_hold, m_en, 4'b0};
         2'd1:    return {m_summ(), m_flag, 4'b0};
         2'd2:    return {bk, 7'b0};
         default: return 8'h00;
      endcase
   endfunction

   function automatic string rd_tag(input logic [1:0] a);
      case (a)
         2'd0:    return "R7";
         2'd1:    return "R2";
         2'd2:    return "R6";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // drive one cycle at the falling edge, check combinational outputs, then advance the model
   task automatic step(input logic t, input logic a, input logic u, input logic rd,
                       input logic wr, input logic [1:0] ad, input logic [7:0] wd, input logic bk);
      logic [7:0] e;
      logic clr;
      @(negedge clk);
      tick_i = t; alarm_i = a; upd_end_i = u; reg_rd = rd; reg_wr = wr;
      reg_addr = ad; reg_wdata = wd; bkup_ok_i = bk;
      #1;
      e = m_read(ad, bk);
      check(reg_rdata == e, rd_tag(ad), reg_rdata, e);
      check(irq_n == !m_summ(), "R3", {7'b0, irq_n}, {7'b0, !m_summ()});
      check(xfer_hold == m_hold, "R8", {7'b0, xfer_hold}, {7'b0, m_hold});
      @(posedge clk);
      clr = rd && (ad == 2'd1);
      m_flag = {t, a, u} | (m_flag & ~{3{clr}});
      if (wr && ad == 2'd0) begin
         m_hold = wd[7];
         m_en   = {wd[6:5], wd[7] ? 1'b0 : wd[4]};
      end
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 2'd1, 8'h00, 1'b1);
   endtask

   task automatic peek(input logic [1:0] ad, input logic [7:0] lit, input string tag);
      @(negedge clk);
      tick_i = 0; alarm_i = 0; upd_end_i = 0; reg_rd = 0; reg_wr = 0;
      reg_addr = ad; bkup_ok_i = 1'b1;
      #1;
      check(reg_rdata == lit, tag, reg_rdata, lit);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual 0x00 expected 0x01");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      peek(2'd1, 8'h00, "R1");
      check(irq_n == 1'b1, "R1", {7'b0, irq_n}, 8'h01);
      peek(2'd0, 8'h00, "R1");
      // R2 periodic latches, R4 read clears
      step(1, 0, 0, 0, 0, 2'd1, 8'h00, 1);
      peek(2'd1, 8'h40, "R2");
      step(0, 0, 0, 1, 0, 2'd1, 8'h00, 1);
      peek(2'd1, 8'h00, "R4");
      // R5 alarm coincides with clearing read
      step(0, 0, 1, 0, 0, 2'd1, 8'h00, 1);
      step(0, 1, 0, 1, 0, 2'd1, 8'h00, 1);
      peek(2'd1, 8'h20, "R5");
      // R9 write to status and integrity ignored
      step(0, 0, 0, 0, 1, 2'd1, 8'hFF, 1);
      step(0, 0, 0, 0, 1, 2'd2, 8'hFF, 1);
      peek(2'd1, 8'h20, "R9");
      peek(2'd0, 8'h00, "R9");
      // R3 enable alarm -> interrupt
      step(0, 0, 0, 0, 1, 2'd0, 8'h20, 1);
      peek(2'd1, 8'hA0, "R3");
      check(irq_n == 1'b0, "R3", {7'b0, irq_n}, 8'h00);
      // R8 hold with bit 4 set
      step(0, 0, 0, 0, 1, 2'd0, 8'hFF, 1);
      peek(2'd0, 8'hE0, "R8");
      check(xfer_hold == 1'b1, "R8", {7'b0, xfer_hold}, 8'h01);
      step(0, 0, 0, 0, 1, 2'd0, 8'h10, 1);
      peek(2'd0, 8'h10, "R7");
      // R6 integrity follows input directly
      @(negedge clk); reg_addr = 2'd2; bkup_ok_i = 1'b0; #1;
      check(reg_rdata == 8'h00, "R6", reg_rdata, 8'h00);
      // R10 unmapped address
      peek(2'd3, 8'h00, "R10");
      // random traffic
      for (int i = 0; i < 600; i++) begin
         step(($urandom % 6) == 0, ($urandom % 7) == 0, ($urandom % 5) == 0,
              ($urandom % 4) == 0, ($urandom % 5) == 0, 2'($urandom % 4),
              8'($urandom), 1'($urandom));
      end
      idle();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule